// File: doc/BRIEF.md
# Overlapping-Window Register File

This block is the integer register file of a multithreaded core. A procedure sees 24 registers: eight outputs, eight locals and eight inputs. The input registers of a called procedure are the same storage as the output registers of its caller. Arguments and results therefore pass between caller and callee without any copy.

Each thread owns a bank of storage and a current-window pointer. Its bank holds `WINDOWS` windows of sixteen private slots, for the outs and the locals. The ins need no slots of their own because they borrow the outs of the neighbouring window. A save command moves the thread's pointer down one window, into the callee. A restore command moves it back up. A save with every window in use, or a restore at the bottom window, raises a one-cycle flag and leaves the pointer where it is. Trap handling for these flags is outside the block.

Three read ports are served every cycle. Two write ports are also served: one for short-latency results and one for long-latency results that return late, possibly from another thread.

Top module: `ow_regfile`

## Requirements
- R1: After reset every register reads zero, every thread's window pointer is 0, and both flags are low.
- R2: Architectural indices 8–15 (outs) and 16–23 (locals) are private to the current window. A write to a local in one window does not appear in another window.
- R3: Index 24+k (an in) in window w is the same storage as index 8+k (an out) in window w+1, modulo `WINDOWS`.
- R4: A save decrements the thread's window pointer and a restore increments it, both modulo `WINDOWS`. `win_o` shows the pointer of thread `tid`.
- R5: A save when the thread already holds `WINDOWS`-1 saved frames raises `ovf_o` in the next cycle and leaves the pointer unchanged. `ovf_o` and `unf_o` are never high together.
- R6: A restore when the thread holds no saved frame raises `unf_o` in the next cycle and leaves the pointer unchanged.
- R7: Save and restore asserted in the same cycle have no effect and raise no flag.
- R8: Each read port returns the register addressed in one cycle on the port's data output in the next cycle. If that register is written in the addressing cycle, the read returns the old value.
- R9: The short and long write ports can each write one register per cycle. If both target the same physical register in one cycle, the long-latency data is kept.
- R10: Indices 0–7 always read as zero, and writes to them are ignored.
- R11: Each thread has its own bank and window pointer. The long port writes into the current window of thread `lw_tid`, while reads, short writes and save/restore use thread `tid`.
- R12: Reads and writes in a cycle that also carries a save or restore use the window pointer from before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid | input | TW | Thread for reads, short writes, save and restore |
| save_i | input | 1 | Move to callee window |
| restore_i | input | 1 | Return to caller window |
| ra0_i | input | 5 | Read port 0 architectural index |
| ra1_i | input | 5 | Read port 1 architectural index |
| ra2_i | input | 5 | Read port 2 architectural index |
| rd0_o | output | DW | Read port 0 data, one cycle later |
| rd1_o | output | DW | Read port 1 data, one cycle later |
| rd2_o | output | DW | Read port 2 data, one cycle later |
| sw_en | input | 1 | Short-latency write enable |
| sw_addr | input | 5 | Short-latency write index |
| sw_data | input | DW | Short-latency write data |
| lw_en | input | 1 | Long-latency write enable |
| lw_tid | input | TW | Thread of the long-latency write |
| lw_addr | input | 5 | Long-latency write index |
| lw_data | input | DW | Long-latency write data |
| win_o | output | WW | Current window pointer of thread `tid` |
| ovf_o | output | 1 | Save refused, pulsed the cycle after |
| unf_o | output | 1 | Restore refused, pulsed the cycle after |

## Verification
Read data, `ovf_o` and `unf_o` are registered, so they are due one cycle after the inputs that cause them. `win_o` follows the pointer combinationally and shows the moved value just after the edge that performs the move. The bench drives inputs on the falling edge and queues the values expected from a bench-side model of the window layout. A monitor pops and compares all of a cycle's entries 2 ns after the following rising edge, when every result of that cycle has settled and no new inputs have been applied yet.

// File: rtl/ow_regfile.sv
module ow_regfile #(
  parameter int THREADS = 2,
  parameter int WINDOWS = 8,
  parameter int DW      = 32,
  localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int WW     = $clog2(WINDOWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tid,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic [4:0]    ra0_i,
  input  logic [4:0]    ra1_i,
  input  logic [4:0]    ra2_i,
  output logic [DW-1:0] rd0_o,
  output logic [DW-1:0] rd1_o,
  output logic [DW-1:0] rd2_o,
  input  logic          sw_en,
  input  logic [4:0]    sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic          lw_en,
  input  logic [TW-1:0] lw_tid,
  input  logic [4:0]    lw_addr,
  input  logic [DW-1:0] lw_data,
  output logic [WW-1:0] win_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int SLOTS = WINDOWS * 16;
  localparam int DEPTH = THREADS * SLOTS;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = WW + 4;

  logic [DW-1:0] mem   [DEPTH];
  logic [WW-1:0] cwp   [THREADS];
  logic [WW-1:0] depth [THREADS];
  logic [4:0]    ra    [3];
  logic [DW-1:0] rdq   [3];

  function automatic logic [AW-1:0] locate(input logic [TW-1:0] t, input logic [WW-1:0] w,
                                           input logic [4:0] a);
    logic [WW-1:0] ww;
    logic [PW-1:0] p;
    ww = (a[4:3] == 2'b11) ? w + 1'b1 : w;
    p  = {ww, a[4:3] == 2'b10, a[2:0]};
    return AW'(int'(t) * SLOTS + int'(p));
  endfunction

  wire          sv     = save_i & ~restore_i;
  wire          rs     = restore_i & ~save_i;
  wire          full   = depth[tid] == WW'(WINDOWS - 1);
  wire          bottom = depth[tid] == '0;
  wire          sw_hit = sw_en && sw_addr[4:3] != 2'b00;
  wire          lw_hit = lw_en && lw_addr[4:3] != 2'b00;
  wire [AW-1:0] sw_loc = locate(tid, cwp[tid], sw_addr);
  wire [AW-1:0] lw_loc = locate(lw_tid, cwp[lw_tid], lw_addr);

  assign ra[0] = ra0_i;
  assign ra[1] = ra1_i;
  assign ra[2] = ra2_i;
  assign rd0_o = rdq[0];
  assign rd1_o = rdq[1];
  assign rd2_o = rdq[2];
  assign win_o = cwp[tid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (sw_hit && !(lw_hit && lw_loc == sw_loc)) mem[sw_loc] <= sw_data;
      if (lw_hit) mem[lw_loc] <= lw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < THREADS; i++) begin
        cwp[i]   <= '0;
        depth[i] <= '0;
      end
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= sv && full;
      unf_o <= rs && bottom;
      if (sv && !full) begin
        cwp[tid]   <= cwp[tid] - 1'b1;
        depth[tid] <= depth[tid] + 1'b1;
      end else if (rs && !bottom) begin
        cwp[tid]   <= cwp[tid] + 1'b1;
        depth[tid] <= depth[tid] - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) rdq[k] <= '0;
      else rdq[k] <= (ra[k][4:3] == 2'b00) ? '0 : mem[locate(tid, cwp[tid], ra[k])];
    end

    AST_GLOBAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ra[k][4:3] == 2'b00) |=> (rdq[k] == '0)); // R10
  end

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sv && !full) |=> (cwp[$past(tid)] == WW'($past(cwp[tid]) - 1'b1))); // R4
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs && !bottom) |=> (cwp[$past(tid)] == WW'($past(cwp[tid]) + 1'b1))); // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sv && full) |=> (ovf_o && cwp[$past(tid)] == $past(cwp[tid]))); // R5
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs && bottom) |=> (unf_o && cwp[$past(tid)] == $past(cwp[tid]))); // R6
  AST_BOTH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> (!ovf_o && !unf_o && cwp[$past(tid)] == $past(cwp[tid]))); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o)); // R5
endmodule

// File: tb/sim_ow_regfile.sv
module sim_ow_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tid = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [4:0]  ra0_i = 5'd8, ra1_i = 5'd8, ra2_i = 5'd8;
  logic [31:0] rd0_o, rd1_o, rd2_o;
  logic        sw_en = 1'b0, lw_en = 1'b0, lw_tid = 1'b0;
  logic [4:0]  sw_addr = 5'd0, lw_addr = 5'd0;
  logic [31:0] sw_data = '0, lw_data = '0;
  logic [2:0]  win_o;
  logic        ovf_o, unf_o;

  ow_regfile u0 (.*);

  always #5 clk = ~clk;

  typedef struct {int kind; int port; logic [31:0] exp; string tag;} item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic [31:0] m [2][128];
  int mcwp [2];
  int mdep [2];
  bit done = 0;

  function automatic int ph(int w, int a);
    if (a >= 24) return ((w + 1) % 8) * 16 + (a - 24);
    return w * 16 + (a - 8);
  endfunction

  function automatic logic [31:0] mread(int t, int a);
    if (a < 8) return '0;
    return m[t][ph(mcwp[t], a)];
  endfunction

  task automatic push(int kind, int port, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.port = port; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(string tag);
    int t, lt;
    bit sv, rs, sw_ok, lw_ok;
    t = int'(tid); lt = int'(lw_tid);
    push(0, 0, mread(t, ra0_i), tag);
    push(0, 1, mread(t, ra1_i), tag);
    push(0, 2, mread(t, ra2_i), tag);
    sv = save_i && !restore_i;
    rs = restore_i && !save_i;
    push(1, 0, {31'd0, sv && mdep[t] == 7}, tag);
    push(2, 0, {31'd0, rs && mdep[t] == 0}, tag);
    lw_ok = lw_en && lw_addr >= 8;
    sw_ok = sw_en && sw_addr >= 8 &&
            !(lw_ok && lt == t && ph(mcwp[lt], lw_addr) == ph(mcwp[t], sw_addr));
    if (sw_ok) m[t][ph(mcwp[t], sw_addr)] = sw_data;
    if (lw_ok) m[lt][ph(mcwp[lt], lw_addr)] = lw_data;
    if (sv && mdep[t] < 7) begin mcwp[t] = (mcwp[t] + 7) % 8; mdep[t]++; end
    else if (rs && mdep[t] > 0) begin mcwp[t] = (mcwp[t] + 1) % 8; mdep[t]--; end
    push(3, 0, 32'(mcwp[t]), tag);
    @(negedge clk);
    save_i = 0; restore_i = 0; sw_en = 0; lw_en = 0;
  endtask

  task automatic rd3(logic [4:0] a, logic [4:0] b, logic [4:0] c);
    ra0_i = a; ra1_i = b; ra2_i = c;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = (it.port == 0) ? rd0_o : (it.port == 1) ? rd1_o : rd2_o;
          1: act = {31'd0, ovf_o};
          2: act = {31'd0, unf_o};
          default: act = {29'd0, win_o};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind %0d port %0d actual %h expected %h",
                   it.tag, it.kind, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      mcwp[t] = 0; mdep[t] = 0;
      for (int i = 0; i < 128; i++) m[t][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd3(5'd9, 5'd18, 5'd27); step("R1");
    rd3(5'd8, 5'd23, 5'd31); step("R1");
    // R2: outs and locals
    sw_en = 1; sw_addr = 5'd9; sw_data = 32'hA1A1_0001; step("R2");
    sw_en = 1; sw_addr = 5'd18; sw_data = 32'hB2B2_0002; step("R2");
    rd3(5'd9, 5'd18, 5'd17); step("R2");
    // R8: same-cycle write returns old value, then new
    rd3(5'd10, 5'd9, 5'd18);
    sw_en = 1; sw_addr = 5'd10; sw_data = 32'hC3C3_0003; step("R8");
    step("R8");
    // R12 and R3: write an out during a save, read it as an in of the callee
    sw_en = 1; sw_addr = 5'd11; sw_data = 32'hD4D4_0004; save_i = 1; step("R12");
    rd3(5'd27, 5'd18, 5'd25); step("R3");
    rd3(5'd11, 5'd26, 5'd9); step("R2");
    // R3: write an in of the callee, visible as the caller's out after restore
    sw_en = 1; sw_addr = 5'd28; sw_data = 32'hE5E5_0005; step("R3");
    restore_i = 1; step("R4");
    rd3(5'd12, 5'd11, 5'd18); step("R3");
    // R9: collision, long port wins; then both ports to different registers
    sw_en = 1; sw_addr = 5'd16; sw_data = 32'h1111_1111;
    lw_en = 1; lw_tid = 0; lw_addr = 5'd16; lw_data = 32'h2222_2222; step("R9");
    sw_en = 1; sw_addr = 5'd20; sw_data = 32'h3333_3333;
    lw_en = 1; lw_tid = 0; lw_addr = 5'd21; lw_data = 32'h4444_4444;
    rd3(5'd16, 5'd20, 5'd21); step("R9");
    step("R9");
    // R11: second thread has its own bank and pointer
    tid = 1; rd3(5'd9, 5'd16, 5'd18); step("R11");
    sw_en = 1; sw_addr = 5'd9; sw_data = 32'h5555_0001; save_i = 1; step("R11");
    lw_en = 1; lw_tid = 0; lw_addr = 5'd13; lw_data = 32'h6666_0006;
    rd3(5'd25, 5'd9, 5'd13); step("R11");
    tid = 0; rd3(5'd13, 5'd9, 5'd16); step("R11");
    // R10: globals read zero and ignore writes
    sw_en = 1; sw_addr = 5'd3; sw_data = 32'hDEAD_BEEF;
    lw_en = 1; lw_tid = 0; lw_addr = 5'd5; lw_data = 32'hFEED_F00D;
    rd3(5'd3, 5'd5, 5'd0); step("R10");
    step("R10");
    // R4 and R5: fill every window, then overflow
    rd3(5'd24, 5'd11, 5'd16);
    for (int i = 0; i < 7; i++) begin
      sw_en = 1; sw_addr = 5'd11; sw_data = 32'h7000_0000 + 32'(i);
      save_i = 1; step("R4");
    end
    save_i = 1; step("R5");
    save_i = 1; rd3(5'd27, 5'd11, 5'd9); step("R5");
    step("R5");
    // R7: save and restore together
    save_i = 1; restore_i = 1; step("R7");
    step("R7");
    // R4 and R6: unwind to bottom, then underflow
    for (int i = 0; i < 7; i++) begin
      rd3(5'd27, 5'd11, 5'd18);
      restore_i = 1; step("R4");
    end
    rd3(5'd11, 5'd16, 5'd10);
    restore_i = 1; step("R6");
    restore_i = 1; step("R6");
    save_i = 1; restore_i = 1; step("R7");
    step("R6");
    // second thread unwinds independently
    tid = 1; restore_i = 1; rd3(5'd9, 5'd25, 5'd16); step("R11");
    restore_i = 1; step("R6");
    step("R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule